// File: doc/BRIEF.md
# AES Round-Key Schedule Generator

This unit turns a cipher key into the full set of AES round keys before any block is encrypted or decrypted with that key. A single engine serves 128-, 192- and 256-bit keys. The key always arrives on one 256-bit input with the key placed in the upper bits. One start pulse launches the schedule. The user key words are loaded into the store in the launch cycle. After that the engine derives one new 32-bit word per clock until 44, 52 or 60 words are held. It uses the standard word recurrence: rotate, byte substitution and round constant every Nk words, plus an extra substitution at mid-period for 256-bit keys.

A cipher datapath placed next to this unit reads round keys through a random-access port. The port is a plain address/data pair with a combinational result and no handshake, so it cannot apply back-pressure. A key that has not finished expanding is marked only by the finish flag. That flag is low while the schedule runs and high whenever the unit is idle, including straight after reset. Consumers must wait for it before using the store. The byte substitution is computed arithmetically and is not held as a table.

Top module: `kx_key_expand`

## Requirements
- R1: After reset `exp_done` is high and every word of the round-key store reads as zero.
- R2: `key_len` selects the key size: 2'b00 gives Nk=4 (44 words), 2'b01 gives Nk=6 (52 words), 2'b10 gives Nk=8 (60 words). Store word j for j < Nk equals `key_in[255-32*j -: 32]`. A start accepted while idle pulls `exp_done` low on the next cycle.
- R3: After an accepted start, `exp_done` reads low for exactly (word count − Nk) cycles (40, 46 or 52) and then returns high.
- R4: Word i (i ≥ Nk) equals word i−Nk XOR t. Here t = Sub(Rot(w[i−1])) XOR {rc,24'h0} when i mod Nk = 0. When Nk = 8 and i mod 8 = 4, t = Sub(w[i−1]). Otherwise t = w[i−1]. Rot moves the top byte to the bottom. rc starts at 8'h01 and is doubled in GF(2^8) (polynomial 0x11B) after each use.
- R5: Sub replaces each byte by its GF(2^8) inverse (zero maps to zero) followed by the AES affine map with constant 8'h63, so the known-answer last words are 32'hb6630ca6, 32'h01002202 and 32'h706c631e.
- R6: A start pulse while `exp_done` is low is ignored: timing and the finished store match the first key alone.
- R7: A start pulse with `key_len` = 2'b11 is ignored: `exp_done` stays high and the store keeps its previous contents.
- R8: The reserved `round_cfg` input has no effect. The round count always follows `key_len`.
- R9: Changes on `key_in` or `key_len` after the launch cycle do not affect the words produced.
- R10: `rd_word` shows the store word at `rd_addr` in the same cycle. Addresses 60 and above read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| key_in | input | 256 | Cipher key, upper-bit aligned, unused low bits zero |
| key_len | input | 2 | Key size select (00/01/10, 11 reserved) |
| round_cfg | input | 4 | Reserved round count, tie to zero |
| exp_start | input | 1 | One-cycle launch pulse |
| exp_done | output | 1 | High when idle, low while the schedule runs |
| rd_addr | input | 6 | Round-key word address |
| rd_word | output | 32 | Round-key word at `rd_addr` |

## Verification
The bench aims at the three places where the key lengths differ. The first is the round-constant sequence. A wrong constant would corrupt every word from index Nk onward. The second is the extra mid-period substitution of 256-bit keys, which is omitted or misplaced if the phase counter slips. The third is the exact busy length, where an off-by-one would leave the flag low one cycle short or long. Starts arriving mid-run, a reserved length code and key inputs that change during a run are all driven. A design that restarted or re-sampled the key would produce words that do not match the behavioural model or the known-answer words.

// File: rtl/kx_pkg.sv
package kx_pkg;
  localparam int WORD_W = 32;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    KLEN_128  = 2'b00,
    KLEN_192  = 2'b01,
    KLEN_256  = 2'b10,
    KLEN_RSVD = 2'b11
  } klen_e;

  // Multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1.
  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) acc = acc ^ sh;
      sh = xtime(sh);
    end
    return acc;
  endfunction

  // Key words per key size.
  function automatic logic [3:0] nk_of(input logic [1:0] sel);
    case (klen_e'(sel))
      KLEN_128: return 4'd4;
      KLEN_192: return 4'd6;
      default:  return 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/kx_sbox.sv
module kx_sbox
  import kx_pkg::*;
(
  input  logic [7:0] din,
  output logic [7:0] dout
);
  logic [7:0] p2, p4, p8, p16, p32, p64, p128;
  logic [7:0] inv;

  // Inverse as din^254 = product of din^(2^k) for k = 1..7.
  always_comb begin
    p2   = gf_mul(din, din);
    p4   = gf_mul(p2, p2);
    p8   = gf_mul(p4, p4);
    p16  = gf_mul(p8, p8);
    p32  = gf_mul(p16, p16);
    p64  = gf_mul(p32, p32);
    p128 = gf_mul(p64, p64);
    inv  = gf_mul(gf_mul(gf_mul(p2, p4), gf_mul(p8, p16)),
                  gf_mul(gf_mul(p32, p64), p128));
  end

  assign dout = inv
              ^ {inv[6:0], inv[7]}
              ^ {inv[5:0], inv[7:6]}
              ^ {inv[4:0], inv[7:5]}
              ^ {inv[3:0], inv[7:4]}
              ^ 8'h63;

  // R5: zero has no inverse and must map to the affine constant.
  always_comb begin
    p_sbox_zero_r5: assert (din != 8'h00 || dout == 8'h63);
  end
endmodule

// File: rtl/kx_subword.sv
module kx_subword
  import kx_pkg::*;
(
  input  word_t din,
  output word_t dout
);
  for (genvar b = 0; b < WORD_W / 8; b++) begin : g_byte
    kx_sbox u_box (
      .din  (din[8*b +: 8]),
      .dout (dout[8*b +: 8])
    );
  end
endmodule

// File: rtl/kx_store.sv
module kx_store
  import kx_pkg::*;
#(
  parameter int MAX_NK    = 8,
  parameter int MAX_WORDS = 60,
  parameter int ADDR_W    = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_en,
  input  logic [3:0]               load_nk,
  input  logic [MAX_NK*WORD_W-1:0] load_vec,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  word_t                    wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  output word_t                    rd_data
);
  word_t mem_q [MAX_WORDS];

  for (genvar j = 0; j < MAX_WORDS; j++) begin : g_entry
    if (j < MAX_NK) begin : g_keyslot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 mem_q[j] <= '0;
        else if (load_en && (4'(j) < load_nk))      mem_q[j] <= load_vec[(MAX_NK-j)*WORD_W-1 -: WORD_W];
        else if (wr_en && wr_addr == ADDR_W'(j))    mem_q[j] <= wr_data;
      end
    end else begin : g_derived
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 mem_q[j] <= '0;
        else if (wr_en && wr_addr == ADDR_W'(j))    mem_q[j] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int j = 0; j < MAX_WORDS; j++) begin
      if (rd_addr == ADDR_W'(j)) rd_data = mem_q[j];
    end
  end

  // R4: derived writes stay inside the store and never collide with a key load.
  p_wr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_addr) < MAX_WORDS));
  p_no_clash_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && load_en));
endmodule

// File: rtl/kx_sched.sv
module kx_sched
  import kx_pkg::*;
#(
  parameter int MAX_NK    = 8,
  parameter int MAX_WORDS = 60,
  parameter int ADDR_W    = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     launch,
  input  logic [MAX_NK*WORD_W-1:0] key_vec,
  input  logic [3:0]               nk_in,
  input  logic [ADDR_W-1:0]        last_in,
  output logic                     busy,
  output logic                     wr_en,
  output logic [ADDR_W-1:0]        wr_addr,
  output word_t                    wr_data
);
  localparam int PH_W = $clog2(MAX_NK);

  word_t             kw       [MAX_NK];
  word_t             load_win [MAX_NK];
  word_t             win_q    [MAX_NK];
  logic [ADDR_W-1:0] idx_q, last_q;
  logic [PH_W-1:0]   phase_q;
  logic [7:0]        rcon_q;
  logic [3:0]        nk_q;
  logic              busy_q;

  word_t prev_w, old_w, rot_w, sub_in, sub_out, temp_w, next_w;
  logic  at_rot, at_sub, phase_wrap;

  // Split the key vector into words, word 0 at the top.
  always_comb begin
    for (int j = 0; j < MAX_NK; j++) kw[j] = key_vec[(MAX_NK-j)*WORD_W-1 -: WORD_W];
  end

  // Window slot k holds w[i-1-k]; at launch i = Nk, so slot k = key word Nk-1-k.
  always_comb begin
    for (int k = 0; k < MAX_NK; k++) begin
      load_win[k] = '0;
      for (int j = 0; j < MAX_NK; j++) begin
        if (4'(j + k + 1) == nk_in) load_win[k] = kw[j];
      end
    end
  end

  // w[i-Nk] sits in slot Nk-1.
  always_comb begin
    old_w = '0;
    for (int k = 0; k < MAX_NK; k++) begin
      if (nk_q == 4'(k + 1)) old_w = win_q[k];
    end
  end

  assign prev_w     = win_q[0];
  assign at_rot     = (phase_q == '0);
  assign at_sub     = (nk_q == 4'd8) && (phase_q == PH_W'(4));
  assign phase_wrap = (4'(phase_q) == nk_q - 4'd1);
  assign rot_w      = {prev_w[WORD_W-9:0], prev_w[WORD_W-1 -: 8]};
  assign sub_in     = at_rot ? rot_w : prev_w;

  kx_subword u_sub (
    .din  (sub_in),
    .dout (sub_out)
  );

  always_comb begin
    if (at_rot)      temp_w = sub_out ^ {rcon_q, 24'h000000};
    else if (at_sub) temp_w = sub_out;
    else             temp_w = prev_w;
    next_w = old_w ^ temp_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < MAX_NK; k++) win_q[k] <= '0;
      idx_q   <= '0;
      last_q  <= '0;
      phase_q <= '0;
      rcon_q  <= 8'h01;
      nk_q    <= 4'd4;
      busy_q  <= 1'b0;
    end else if (launch) begin
      for (int k = 0; k < MAX_NK; k++) win_q[k] <= load_win[k];
      idx_q   <= ADDR_W'(nk_in);
      last_q  <= last_in;
      phase_q <= '0;
      rcon_q  <= 8'h01;
      nk_q    <= nk_in;
      busy_q  <= 1'b1;
    end else if (busy_q) begin
      win_q[0] <= next_w;
      for (int k = 1; k < MAX_NK; k++) win_q[k] <= win_q[k-1];
      idx_q   <= idx_q + 1'b1;
      phase_q <= phase_wrap ? '0 : phase_q + 1'b1;
      if (at_rot)          rcon_q <= xtime(rcon_q);
      if (idx_q == last_q) busy_q <= 1'b0;
    end
  end

  assign busy    = busy_q;
  assign wr_en   = busy_q;
  assign wr_addr = idx_q;
  assign wr_data = next_w;

  // R4: only the ten standard round constants are ever applied.
  p_rcon_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && at_rot) |-> ($onehot(rcon_q) || rcon_q == 8'h1b || rcon_q == 8'h36));
  // R4: phase stays inside one key period.
  p_phase_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (4'(phase_q) < nk_q));
  // R3: the index walks one word per cycle between Nk and the last word.
  p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (idx_q >= ADDR_W'(nk_q) && idx_q <= last_q));
  p_idx_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && idx_q != last_q) |=> (busy_q && idx_q == $past(idx_q) + 1'b1));
  p_finish_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && idx_q == last_q) |=> !busy_q);
  // R6: key size is frozen for the whole run.
  p_nk_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && idx_q != last_q) |=> nk_q == $past(nk_q));
endmodule

// File: rtl/kx_key_expand.sv
module kx_key_expand
  import kx_pkg::*;
#(
  parameter  int KEY_W     = 256,
  localparam int MAX_NK    = KEY_W / WORD_W,
  localparam int MAX_WORDS = 4 * (MAX_NK + 7),
  localparam int ADDR_W    = $clog2(MAX_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [KEY_W-1:0]  key_in,
  input  logic [1:0]        key_len,
  input  logic [3:0]        round_cfg,
  input  logic              exp_start,
  output logic              exp_done,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_word
);
  logic [3:0]        nk_sel;
  logic [ADDR_W-1:0] last_word;
  logic              launch, busy;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  word_t             wr_data;
  logic              cfg_unused;

  // The reserved round count is not used: rounds always follow key size.
  assign cfg_unused = ^round_cfg;

  assign nk_sel    = nk_of(key_len);
  assign last_word = ADDR_W'(4 * (int'(nk_sel) + 7) - 1);
  assign launch    = exp_start && !busy && (klen_e'(key_len) != KLEN_RSVD);
  assign exp_done  = !busy;

  kx_sched #(
    .MAX_NK    (MAX_NK),
    .MAX_WORDS (MAX_WORDS),
    .ADDR_W    (ADDR_W)
  ) u_sched (
    .clk     (clk),
    .rst_n   (rst_n),
    .launch  (launch),
    .key_vec (key_in),
    .nk_in   (nk_sel),
    .last_in (last_word),
    .busy    (busy),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  kx_store #(
    .MAX_NK    (MAX_NK),
    .MAX_WORDS (MAX_WORDS),
    .ADDR_W    (ADDR_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (launch),
    .load_nk  (nk_sel),
    .load_vec (key_in),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_word)
  );

  // R1: the first cycle out of reset is idle.
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> exp_done);
  // R2: an accepted start makes the unit busy on the next cycle.
  p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_start && exp_done && key_len != 2'b11) |=> !exp_done);
  // R7: the reserved size code never launches.
  p_bad_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_start && exp_done && key_len == 2'b11) |=> exp_done);
endmodule

// File: tb/test_kx_key_expand.sv
`timescale 1ns/1ps
module test_kx_key_expand;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [255:0] key_in = '0;
  logic [1:0]   key_len = 2'b00;
  logic [3:0]   round_cfg = 4'h0;
  logic         exp_start = 1'b0;
  logic         exp_done;
  logic [5:0]   rd_addr = '0;
  logic [31:0]  rd_word;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  int m_left = 0;
  logic [7:0]  sb [256];
  logic [31:0] exp_w [60];

  always #10 clk = ~clk;

  kx_key_expand i_kx_key_expand (
    .clk(clk), .rst_n(rst_n), .key_in(key_in), .key_len(key_len),
    .round_cfg(round_cfg), .exp_start(exp_start), .exp_done(exp_done),
    .rd_addr(rd_addr), .rd_word(rd_word)
  );

  function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p = 16'h0;
    for (int k = 0; k < 8; k++) if (b[k]) p = p ^ (16'(a) << k);
    for (int k = 15; k >= 8; k--) if (p[k]) p = p ^ (16'h011b << (k - 8));
    return p[7:0];
  endfunction

  function automatic logic [31:0] bsub(input logic [31:0] w);
    return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
  endfunction

  function automatic int nk_for(input logic [1:0] l);
    return (l == 2'b00) ? 4 : (l == 2'b01) ? 6 : 8;
  endfunction

  task automatic build_sbox();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv = 8'h00;
      logic [7:0] r;
      if (x != 0) for (int y = 1; y < 256; y++) if (bmul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      for (int i = 0; i < 8; i++)
        r[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 1);
      sb[x] = r;
    end
  endtask

  task automatic ref_expand(input logic [255:0] k, input logic [1:0] l);
    int nk = nk_for(l);
    int tot = 4 * (nk + 7);
    logic [7:0] rc = 8'h01;
    for (int i = 0; i < nk; i++) exp_w[i] = k[255-32*i -: 32];
    for (int i = nk; i < tot; i++) begin
      logic [31:0] t = exp_w[i-1];
      if (i % nk == 0) begin
        t = bsub({t[23:0], t[31:24]}) ^ {rc, 24'h0};
        rc = bmul(rc, 8'h02);
      end else if (nk == 8 && i % nk == 4) begin
        t = bsub(t);
      end
      exp_w[i] = exp_w[i-nk] ^ t;
    end
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural busy model: counts remaining busy cycles.
  always @(posedge clk) begin
    if (!rst_n) m_left <= 0;
    else if (m_left > 0) m_left <= m_left - 1;
    else if (exp_start && key_len != 2'b11) m_left <= 3 * nk_for(key_len) + 28;
  end

  // R3: finish flag compared on every cycle.
  always @(negedge clk) begin
    if (rst_n && !finished) chk(exp_done === (m_left == 0), "R3", 32'(exp_done), 32'(m_left == 0));
  end

  task automatic pulse(input logic [255:0] k, input logic [1:0] l, input logic [3:0] cfg);
    @(negedge clk);
    key_in = k; key_len = l; round_cfg = cfg; exp_start = 1'b1;
    @(negedge clk);
    exp_start = 1'b0;
  endtask

  task automatic wait_idle();
    while (exp_done !== 1'b1) @(negedge clk);
  endtask

  task automatic read_at(input int a, output logic [31:0] v);
    @(negedge clk);
    rd_addr = 6'(a);
    #2 v = rd_word;
  endtask

  task automatic check_words(input int tot, input string req);
    logic [31:0] v;
    for (int a = 0; a < tot; a++) begin
      read_at(a, v);
      chk(v === exp_w[a], req, v, exp_w[a]);
    end
  endtask

  function automatic logic [255:0] rand_key(input logic [1:0] l);
    logic [255:0] k = {$urandom(), $urandom(), $urandom(), $urandom(),
                       $urandom(), $urandom(), $urandom(), $urandom()};
    if (l == 2'b00) k[127:0] = '0;
    if (l == 2'b01) k[63:0] = '0;
    return k;
  endfunction

  task automatic run_case(input logic [255:0] k, input logic [1:0] l, input logic [3:0] cfg, input string req);
    ref_expand(k, l);
    pulse(k, l, cfg);
    wait_idle();
    check_words(4 * (nk_for(l) + 7), req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R3 watchdog: act=hung exp=idle");
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [255:0] ka;
    build_sbox();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(exp_done === 1'b1, "R1", 32'(exp_done), 32'h1);
    read_at(0, v);  chk(v === 32'h0, "R1", v, 32'h0);
    read_at(59, v); chk(v === 32'h0, "R1", v, 32'h0);

    // Known-answer keys, R2 / R4 / R5.
    run_case({128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0}, 2'b00, 4'h0, "R4");
    read_at(0, v);  chk(v === 32'h2b7e1516, "R2", v, 32'h2b7e1516);
    read_at(43, v); chk(v === 32'hb6630ca6, "R5", v, 32'hb6630ca6);
    run_case({192'h8e73b0f7da0e6452c810f32b809079e562f8ead2522c6b7b, 64'h0}, 2'b01, 4'h0, "R4");
    read_at(51, v); chk(v === 32'h01002202, "R5", v, 32'h01002202);
    run_case(256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4, 2'b10, 4'h0, "R4");
    read_at(7, v);  chk(v === 32'h0914dff4, "R2", v, 32'h0914dff4);
    read_at(59, v); chk(v === 32'h706c631e, "R5", v, 32'h706c631e);

    // Random keys of every size.
    for (int r = 0; r < 2; r++)
      for (int l = 0; l < 3; l++) run_case(rand_key(2'(l)), 2'(l), 4'h0, "R2");

    // R6 / R9: start mid-run and key inputs moving during the run.
    ka = rand_key(2'b00);
    ref_expand(ka, 2'b00);
    pulse(ka, 2'b00, 4'h0);
    repeat (5) @(negedge clk);
    key_in = rand_key(2'b10); key_len = 2'b10; exp_start = 1'b1;
    @(negedge clk);
    exp_start = 1'b0; key_in = rand_key(2'b01); key_len = 2'b01;
    wait_idle();
    check_words(44, "R6");
    read_at(0, v); chk(v === ka[255:224], "R9", v, ka[255:224]);

    // R7: reserved size code leaves the store alone.
    pulse(rand_key(2'b10), 2'b11, 4'h0);
    repeat (3) @(negedge clk);
    chk(exp_done === 1'b1, "R7", 32'(exp_done), 32'h1);
    check_words(44, "R7");

    // R8: reserved round count has no effect.
    run_case(rand_key(2'b01), 2'b01, 4'hA, "R8");
    run_case(rand_key(2'b00), 2'b00, 4'hF, "R8");

    // R10: out-of-range address reads zero.
    read_at(62, v); chk(v === 32'h0, "R10", v, 32'h0);
    read_at(60, v); chk(v === 32'h0, "R10", v, 32'h0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule